// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This block performs the state changes of taking a trap in a 32-bit hart. A trap request carries either an exception code or an interrupt number with a flag, plus the faulting address and the PC of the trapping instruction. The block applies these changes in a single clock edge:

- It rewrites an environment-call code to match the current privilege.
- It builds the cause word.
- It consults the delegation masks to pick the supervisor or machine handler.
- It fills the selected cause, exception-PC and trap-value registers.
- It pushes the interrupt-enable and privilege stack bits.
- It switches privilege and redirects the PC to the selected vector.

All state it writes is visible on output ports. Vector bases and delegation masks are plain inputs from the CSR file.

Requests use a valid/ready handshake. `trap_ready` is low during reset and high from the first clock after reset, so there is no back-pressure while running. A request is consumed on every rising edge where `trap_valid` and `trap_ready` are both high. The requester must hold its fields stable while `trap_valid` is high. A separate context-load strobe lets the core set the privilege and the two interrupt-enable bits, for example after a trap return handled elsewhere. An accepted trap in the same cycle takes precedence over that strobe.

Top module: `trap_entry_ctrl`

## Requirements
- R1: In reset `trap_ready` is 0; after reset the privilege is machine (3), and the PC, all cause, exception-PC and trap-value outputs, the stack bits and `redir_valid` are 0.
- R2: `trap_ready` is 1 from the first clock after reset. A trap is taken only on an edge where `trap_valid` and `trap_ready` are both 1; without one, the cause, exception-PC, trap-value and PC outputs keep their values.
- R3: For an interrupt, the cause word is bit 31 set with the interrupt number (`trap_code`, 5 bits) in bits 4:0. For an exception, bit 31 is 0 and the code sits in the low bits.
- R4: Exception code 8 (environment call) is reported as cause 8 from user (privilege 0), 9 from supervisor (privilege 1) and 11 from machine (privilege 3).
- R5: The target is supervisor only when the current privilege is 0 or 1 and the delegation bit is set. Interrupts index `irq_deleg` by the interrupt number; exceptions index `exc_deleg` by the reported cause code. Otherwise the target is machine, so a trap from machine always stays in machine.
- R6: A supervisor trap performs these updates and leaves every machine output unchanged:
  - sets the PC to `sup_vec` with bits 1:0 forced to 0;
  - writes `scause` and `sepc` (`trap_pc`);
  - copies SIE into SPIE and stores bit 0 of the old privilege in SPP;
  - clears SIE and sets the privilege to 1.
- R7: A machine trap performs these updates and leaves every supervisor output unchanged:
  - sets the PC to `mach_vec` with bits 1:0 forced to 0;
  - writes `mcause` and `mepc`;
  - copies MIE into MPIE and stores the old 2-bit privilege in MPP;
  - clears MIE and sets the privilege to 3.
- R8: The selected trap-value register takes `trap_tval` only for exception codes 0, 1, 4, 5, 6, 7, 12, 13 and 15. For any other exception, and for every interrupt, it is written with 0.
- R9: When no trap is accepted, `ctx_wr` loads the privilege from `ctx_priv`, mapping the reserved value 2 to user (0), and loads SIE from `ctx_sie` and MIE from `ctx_mie`. When a trap is accepted on the same edge, `ctx_wr` has no effect.
- R10: `redir_valid` is 1 for exactly the one cycle after each accepted trap and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Trap request present |
| trap_ready | output | 1 | Block can accept a request |
| trap_is_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_code | input | 5 | Interrupt number or exception code |
| trap_tval | input | 32 | Faulting address |
| trap_pc | input | 32 | PC of the trapping instruction |
| irq_deleg | input | 32 | Interrupt delegation mask |
| exc_deleg | input | 32 | Exception delegation mask |
| sup_vec | input | 32 | Supervisor handler base |
| mach_vec | input | 32 | Machine handler base |
| ctx_wr | input | 1 | Load privilege and enable bits |
| ctx_priv | input | 2 | Privilege to load |
| ctx_sie | input | 1 | SIE value to load |
| ctx_mie | input | 1 | MIE value to load |
| cur_priv | output | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| pc_out | output | 32 | Redirected PC |
| redir_valid | output | 1 | PC redirect pulse |
| scause | output | 32 | Supervisor cause |
| sepc | output | 32 | Supervisor exception PC |
| stval | output | 32 | Supervisor trap value |
| mcause | output | 32 | Machine cause |
| mepc | output | 32 | Machine exception PC |
| mtval | output | 32 | Machine trap value |
| st_sie | output | 1 | Supervisor interrupt enable |
| st_spie | output | 1 | Previous SIE |
| st_spp | output | 1 | Previous privilege for supervisor |
| st_mie | output | 1 | Machine interrupt enable |
| st_mpie | output | 1 | Previous MIE |
| st_mpp | output | 2 | Previous privilege for machine |

## Verification
Every defect in this block appears at the ports on the edge that accepts the trap. A wrong privilege or enable bit shows up in `cur_priv` or the stack bits. Wrong delegation shows up as the opposite register bank changing and the PC taking the other vector. A wrong cause fixup or trap-value filter shows up in the written registers.

Some faults are latent. A stale privilege or enable value only corrupts what a later trap stores into SPP, MPP, SPIE or MPIE. For that reason the bench chains many traps and context loads, so that such latent errors surface one trap later.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int XLEN = 32;
  localparam logic [1:0] PRIV_U    = 2'd0;
  localparam logic [1:0] PRIV_S    = 2'd1;
  localparam logic [1:0] PRIV_RSVD = 2'd2;
  localparam logic [1:0] PRIV_M    = 2'd3;
  localparam int ECALL_U = 8;
  localparam int ECALL_S = 9;
  localparam int ECALL_M = 11;
  // codes whose trap value is the faulting address: 0,1,4,5,6,7,12,13,15
  localparam logic [31:0] ADDR_CODES = 32'h0000_B0F3;
endpackage

// File: rtl/trap_cause_fix.sv
module trap_cause_fix
  import trap_pkg::*;
#(
  parameter int XW     = 32,
  parameter int CODE_W = $clog2(XW)
) (
  input  logic              is_irq,
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        priv,
  output logic [CODE_W-1:0] fixed_code,
  output logic [XW-1:0]     cause,
  output logic              keep_addr
);
  always_comb begin
    fixed_code = code;
    if (!is_irq && code == CODE_W'(ECALL_U)) begin
      case (priv)
        PRIV_S:  fixed_code = CODE_W'(ECALL_S);
        PRIV_M:  fixed_code = CODE_W'(ECALL_M);
        default: fixed_code = CODE_W'(ECALL_U);
      endcase
    end
    cause = '0;
    cause[CODE_W-1:0] = fixed_code;
    cause[XW-1] = is_irq;
    keep_addr = !is_irq && ADDR_CODES[fixed_code];
  end
endmodule

// File: rtl/trap_target_sel.sv
module trap_target_sel
  import trap_pkg::*;
#(
  parameter int XW     = 32,
  parameter int CODE_W = $clog2(XW)
) (
  input  logic              is_irq,
  input  logic [CODE_W-1:0] fixed_code,
  input  logic [1:0]        priv,
  input  logic [XW-1:0]     irq_mask,
  input  logic [XW-1:0]     exc_mask,
  output logic              to_sup
);
  logic [XW-1:0] mask;
  always_comb begin
    mask   = is_irq ? irq_mask : exc_mask;
    to_sup = (priv == PRIV_U || priv == PRIV_S) && mask[fixed_code];
  end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int XW     = XLEN,
  parameter int CODE_W = $clog2(XW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_valid,
  output logic              trap_ready,
  input  logic              trap_is_irq,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XW-1:0]     trap_tval,
  input  logic [XW-1:0]     trap_pc,
  input  logic [XW-1:0]     irq_deleg,
  input  logic [XW-1:0]     exc_deleg,
  input  logic [XW-1:0]     sup_vec,
  input  logic [XW-1:0]     mach_vec,
  input  logic              ctx_wr,
  input  logic [1:0]        ctx_priv,
  input  logic              ctx_sie,
  input  logic              ctx_mie,
  output logic [1:0]        cur_priv,
  output logic [XW-1:0]     pc_out,
  output logic              redir_valid,
  output logic [XW-1:0]     scause,
  output logic [XW-1:0]     sepc,
  output logic [XW-1:0]     stval,
  output logic [XW-1:0]     mcause,
  output logic [XW-1:0]     mepc,
  output logic [XW-1:0]     mtval,
  output logic              st_sie,
  output logic              st_spie,
  output logic              st_spp,
  output logic              st_mie,
  output logic              st_mpie,
  output logic [1:0]        st_mpp
);
  logic              rdy_q;
  logic              take;
  logic [CODE_W-1:0] fixed_code;
  logic [XW-1:0]     cause_w;
  logic              keep_addr;
  logic              to_sup;
  logic [XW-1:0]     tval_w;

  assign trap_ready = rdy_q;
  assign take       = trap_valid && rdy_q;
  assign tval_w     = keep_addr ? trap_tval : '0;

  trap_cause_fix #(.XW(XW), .CODE_W(CODE_W)) u_fix (
    .is_irq(trap_is_irq), .code(trap_code), .priv(cur_priv),
    .fixed_code(fixed_code), .cause(cause_w), .keep_addr(keep_addr)
  );

  trap_target_sel #(.XW(XW), .CODE_W(CODE_W)) u_sel (
    .is_irq(trap_is_irq), .fixed_code(fixed_code), .priv(cur_priv),
    .irq_mask(irq_deleg), .exc_mask(exc_deleg), .to_sup(to_sup)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q       <= 1'b0;
      redir_valid <= 1'b0;
      cur_priv    <= PRIV_M;
      pc_out      <= '0;
      scause      <= '0;
      sepc        <= '0;
      stval       <= '0;
      mcause      <= '0;
      mepc        <= '0;
      mtval       <= '0;
      st_sie      <= 1'b0;
      st_spie     <= 1'b0;
      st_spp      <= 1'b0;
      st_mie      <= 1'b0;
      st_mpie     <= 1'b0;
      st_mpp      <= PRIV_U;
    end else begin
      rdy_q       <= 1'b1;
      redir_valid <= take;
      if (take) begin
        if (to_sup) begin
          pc_out   <= {sup_vec[XW-1:2], 2'b00};
          scause   <= cause_w;
          sepc     <= trap_pc;
          stval    <= tval_w;
          st_spie  <= st_sie;
          st_spp   <= cur_priv[0];
          st_sie   <= 1'b0;
          cur_priv <= PRIV_S;
        end else begin
          pc_out   <= {mach_vec[XW-1:2], 2'b00};
          mcause   <= cause_w;
          mepc     <= trap_pc;
          mtval    <= tval_w;
          st_mpie  <= st_mie;
          st_mpp   <= cur_priv;
          st_mie   <= 1'b0;
          cur_priv <= PRIV_M;
        end
      end else if (ctx_wr) begin
        cur_priv <= (ctx_priv == PRIV_RSVD) ? PRIV_U : ctx_priv;
        st_sie   <= ctx_sie;
        st_mie   <= ctx_mie;
      end
    end
  end
endmodule

// File: rtl/trap_entry_ctrl_chk.sv
module trap_entry_ctrl_chk #(
  parameter int XW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trap_valid,
  input logic          trap_ready,
  input logic          trap_is_irq,
  input logic [1:0]    cur_priv,
  input logic [XW-1:0] pc_out,
  input logic          redir_valid,
  input logic [XW-1:0] scause,
  input logic [XW-1:0] mcause,
  input logic [XW-1:0] mtval,
  input logic          st_sie,
  input logic          st_mie
);
  logic acc;
  assign acc = trap_valid && trap_ready;

  AST_TRAP_LEAVES_USER: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc) |-> cur_priv != 2'd0); // R5
  AST_MACHINE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc && cur_priv == 2'd3) |-> cur_priv == 2'd3); // R5
  AST_MIE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc) && cur_priv == 2'd3 |-> !st_mie); // R7
  AST_SIE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc) && cur_priv == 2'd1 |-> !st_sie); // R6
  AST_IRQ_FLAG_M: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc && trap_is_irq) && cur_priv == 2'd3 |-> mcause[XW-1]); // R3
  AST_IRQ_FLAG_S: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc && trap_is_irq) && cur_priv == 2'd1 |-> scause[XW-1]); // R3
  AST_IRQ_NO_TVAL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc && trap_is_irq) && cur_priv == 2'd3 |-> mtval == '0); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc) |-> $stable(mcause) && $stable(scause) && $stable(pc_out)); // R2
  AST_VEC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> pc_out[1:0] == 2'b00); // R6
endmodule

bind trap_entry_ctrl trap_entry_ctrl_chk #(.XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_ready(trap_ready),
  .trap_is_irq(trap_is_irq), .cur_priv(cur_priv), .pc_out(pc_out),
  .redir_valid(redir_valid), .scause(scause), .mcause(mcause), .mtval(mtval),
  .st_sie(st_sie), .st_mie(st_mie)
);

// File: tb/trap_entry_ctrl_tb_top.sv
module trap_entry_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_valid = 1'b0, trap_ready, trap_is_irq = 1'b0;
  logic [4:0]  trap_code = '0;
  logic [31:0] trap_tval = '0, trap_pc = '0;
  logic [31:0] irq_deleg = '0, exc_deleg = '0, sup_vec = '0, mach_vec = '0;
  logic        ctx_wr = 1'b0, ctx_sie = 1'b0, ctx_mie = 1'b0;
  logic [1:0]  ctx_priv = '0;
  logic [1:0]  cur_priv, st_mpp;
  logic [31:0] pc_out, scause, sepc, stval, mcause, mepc, mtval;
  logic        redir_valid, st_sie, st_spie, st_spp, st_mie, st_mpie;

  int checks = 0, fails = 0;

  // bench model of the architectural state
  logic [1:0]  e_priv, e_mpp;
  logic [31:0] e_pc, e_scause, e_sepc, e_stval, e_mcause, e_mepc, e_mtval;
  logic        e_sie, e_spie, e_spp, e_mie, e_mpie;

  always #2 clk = ~clk;

  trap_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_ready(trap_ready),
    .trap_is_irq(trap_is_irq), .trap_code(trap_code), .trap_tval(trap_tval),
    .trap_pc(trap_pc), .irq_deleg(irq_deleg), .exc_deleg(exc_deleg),
    .sup_vec(sup_vec), .mach_vec(mach_vec), .ctx_wr(ctx_wr), .ctx_priv(ctx_priv),
    .ctx_sie(ctx_sie), .ctx_mie(ctx_mie), .cur_priv(cur_priv), .pc_out(pc_out),
    .redir_valid(redir_valid), .scause(scause), .sepc(sepc), .stval(stval),
    .mcause(mcause), .mepc(mepc), .mtval(mtval), .st_sie(st_sie),
    .st_spie(st_spie), .st_spp(st_spp), .st_mie(st_mie), .st_mpie(st_mpie),
    .st_mpp(st_mpp)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] fix_code(input logic irq, input logic [4:0] c, input logic [1:0] p);
    if (!irq && c == 5'd8) return (p == 2'd1) ? 5'd9 : (p == 2'd3) ? 5'd11 : 5'd8;
    return c;
  endfunction

  function automatic logic addr_cause(input logic [4:0] c);
    return c inside {5'd0, 5'd1, 5'd4, 5'd5, 5'd6, 5'd7, 5'd12, 5'd13, 5'd15};
  endfunction

  task automatic compare_all(input logic exp_redir);
    chk("R5 privilege", {30'd0, cur_priv}, {30'd0, e_priv});
    chk("R6/R7 pc", pc_out, e_pc);
    chk("R3/R4 scause", scause, e_scause);
    chk("R3/R4 mcause", mcause, e_mcause);
    chk("R6 sepc", sepc, e_sepc);
    chk("R7 mepc", mepc, e_mepc);
    chk("R8 stval", stval, e_stval);
    chk("R8 mtval", mtval, e_mtval);
    chk("R6/R7/R9 status", {25'd0, st_sie, st_spie, st_spp, st_mie, st_mpie, st_mpp},
        {25'd0, e_sie, e_spie, e_spp, e_mie, e_mpie, e_mpp});
    chk("R10 redirect", {31'd0, redir_valid}, {31'd0, exp_redir});
  endtask

  task automatic model_trap(input logic irq, input logic [4:0] c,
                            input logic [31:0] tv, input logic [31:0] pc);
    logic [4:0]  fc;
    logic [31:0] cause, msk, tvv;
    logic        sup;
    fc    = fix_code(irq, c, e_priv);
    cause = {irq, 26'd0, fc};
    msk   = irq ? irq_deleg : exc_deleg;
    sup   = (e_priv == 2'd0 || e_priv == 2'd1) && msk[fc];
    tvv   = (!irq && addr_cause(fc)) ? tv : 32'd0;
    if (sup) begin
      e_pc = {sup_vec[31:2], 2'b00}; e_scause = cause; e_sepc = pc; e_stval = tvv;
      e_spie = e_sie; e_spp = e_priv[0]; e_sie = 1'b0; e_priv = 2'd1;
    end else begin
      e_pc = {mach_vec[31:2], 2'b00}; e_mcause = cause; e_mepc = pc; e_mtval = tvv;
      e_mpie = e_mie; e_mpp = e_priv; e_mie = 1'b0; e_priv = 2'd3;
    end
  endtask

  task automatic do_trap(input logic irq, input logic [4:0] c, input logic [31:0] tv,
                         input logic [31:0] pc, input logic also_ctx);
    @(negedge clk);
    trap_valid = 1'b1; trap_is_irq = irq; trap_code = c; trap_tval = tv; trap_pc = pc;
    ctx_wr = also_ctx; ctx_priv = 2'd0; ctx_sie = 1'b1; ctx_mie = 1'b1;
    @(posedge clk);
    model_trap(irq, c, tv, pc);
    @(negedge clk);
    trap_valid = 1'b0; ctx_wr = 1'b0;
    compare_all(1'b1);
  endtask

  task automatic do_ctx(input logic [1:0] p, input logic s, input logic m);
    @(negedge clk);
    ctx_wr = 1'b1; ctx_priv = p; ctx_sie = s; ctx_mie = m;
    @(posedge clk);
    e_priv = (p == 2'd2) ? 2'd0 : p; e_sie = s; e_mie = m;
    @(negedge clk);
    ctx_wr = 1'b0;
    compare_all(1'b0);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    e_priv = 2'd3; e_pc = '0; e_scause = '0; e_sepc = '0; e_stval = '0;
    e_mcause = '0; e_mepc = '0; e_mtval = '0;
    e_sie = 0; e_spie = 0; e_spp = 0; e_mie = 0; e_mpie = 0; e_mpp = 2'd0;
    sup_vec = 32'h8000_1003; mach_vec = 32'h0000_4001;
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", {31'd0, trap_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 ready high after reset", {31'd0, trap_ready}, 32'd1);
    compare_all(1'b0); // R1 reset state

    // R4: environment call from each privilege, nothing delegated
    do_ctx(2'd0, 1'b1, 1'b1);
    do_trap(1'b0, 5'd8, 32'hdead_0000, 32'h100, 1'b0);
    chk("R4 ecall from user", mcause, 32'd8);
    do_ctx(2'd1, 1'b1, 1'b1);
    do_trap(1'b0, 5'd8, 32'h0, 32'h104, 1'b0);
    chk("R4 ecall from supervisor", mcause, 32'd9);
    do_trap(1'b0, 5'd8, 32'h0, 32'h108, 1'b0);
    chk("R4 ecall from machine", mcause, 32'd11);

    // R5: everything delegated, machine still traps to machine
    irq_deleg = '1; exc_deleg = '1;
    do_trap(1'b1, 5'd5, 32'h55, 32'h200, 1'b0);
    chk("R5 machine stays machine", {30'd0, cur_priv}, 32'd3);
    // R3, R6: delegated interrupt from user goes to supervisor, vector aligned
    do_ctx(2'd2, 1'b1, 1'b0); // R9 reserved maps to user
    chk("R9 reserved privilege to user", {30'd0, cur_priv}, 32'd0);
    do_trap(1'b1, 5'd9, 32'h77, 32'h300, 1'b0);
    chk("R3 interrupt cause", scause, 32'h8000_0009);
    chk("R6 aligned supervisor vector", pc_out, 32'h8000_1000);
    chk("R8 interrupt clears stval", stval, 32'd0);
    // R8: page fault carries address, illegal instruction does not
    do_ctx(2'd1, 1'b0, 1'b0);
    do_trap(1'b0, 5'd13, 32'hcafe_f00d, 32'h310, 1'b0);
    chk("R8 load page fault keeps address", stval, 32'hcafe_f00d);
    do_ctx(2'd1, 1'b0, 1'b0);
    do_trap(1'b0, 5'd2, 32'hcafe_f00d, 32'h314, 1'b0);
    chk("R8 illegal instruction zero tval", stval, 32'd0);
    // R9: ctx_wr ignored on a trap edge
    do_trap(1'b0, 5'd3, 32'h0, 32'h400, 1'b1);
    chk("R9 ctx ignored with trap", {31'd0, st_mie}, 32'd0);
    // R2, R10: idle cycles hold state, redirect pulse has ended
    trap_code = 5'd1; trap_is_irq = 1'b0;
    repeat (3) @(negedge clk);
    compare_all(1'b0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [4:0] c;
      irq_deleg = $urandom(); exc_deleg = $urandom();
      sup_vec = $urandom(); mach_vec = $urandom();
      if ($urandom_range(0, 2) != 0)
        do_ctx(2'($urandom_range(0, 3)), 1'($urandom()), 1'($urandom()));
      c = ($urandom_range(0, 3) == 0) ? 5'd8 : 5'($urandom_range(0, 31));
      do_trap(1'($urandom()), c, $urandom(), $urandom(), 1'($urandom()));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule